// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode logic that sits behind the analog front end of a single-wire LIN bus transceiver. It tracks three operating modes: standby, normal and sleep. It decides when the external voltage regulator is powered through the inhibit output, and when the bus driver may pull the line dominant. It also decides what the receive-data pin shows to the host controller. The block runs on a system clock and does all timing in microsecond ticks. A one-cycle strobe supplies those ticks, so every filter and timeout is set in microseconds.

While the node sleeps, two sources can wake it. The first is a dominant bus level that persists, which is a remote wake. The second is a falling edge on the active-low wake pin that persists, which is a local wake. Either one returns the node to standby and raises the regulator enable. It also signals the wake on the data pins themselves: the receive pin is held low, and a strong pull-down is applied to the transmit pin only when the wake was local. The host reads these two pins to learn that a wake happened and where it came from. It then raises the enable input, which clears both indications. In normal mode the block also guards against a transmit line stuck dominant, by cutting the driver after a long dominant stretch.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset, the block is in standby with the following outputs: `inh`=1, `drv_en`=0, `rxd`=1 and `txd_strong_pd`=0.
- R2: From standby, `en`=1 leads to normal mode at the next clock edge. Normal mode means `drv_en`=1 and `rxd` follows `bus_rx` (0 = dominant) combinationally.
- R3: In normal mode, `en`=0 leads to sleep at the next clock edge. Sleep means `inh`=0 and `drv_en`=0. With no wake pending, `rxd`=1.
- R4: In sleep, a remote wake happens once `bus_rx`=0 has been sampled on WAKE_FILT_US consecutive tick edges. A shorter dominant run leaves the block asleep with `inh`=0. On a wake the block enters standby with `inh`=1, `rxd`=0 and `drv_en`=0.
- R5: In sleep, a local wake needs `wake_n` to have been seen high during sleep, then to stay low for WAKE_FILT_US tick edges. A low level already present when sleep began does not wake the block.
- R6: `txd_strong_pd`=1 after a local wake and 0 after a remote wake.
- R7: Raising `en` from standby or sleep clears both wake indications. After that, `rxd` follows the bus and `txd_strong_pd`=0.
- R8: From sleep, `en`=1 enters normal mode directly at the next edge, with no wake required. This takes priority over a wake that completes in the same cycle.
- R9: In normal mode, if `txd`=0 is held for TXTO_US tick edges, `drv_en` drops to 0. It returns to 1 only after `txd`=1 has been held for RECOV_US tick edges.
- R10: All filter and timeout counters advance only on cycles with `us_tick`=1.
- R11: If the remote and local wake filters complete in the same cycle, the wake is reported as local, with `txd_strong_pd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up / undervoltage reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| en | input | 1 | Mode enable from host; high selects normal |
| wake_n | input | 1 | Local wake pin, active low |
| bus_rx | input | 1 | Comparator bus level, 0 = dominant |
| txd | input | 1 | Host transmit data, 0 = dominant |
| inh | output | 1 | Regulator enable; 0 in sleep |
| drv_en | output | 1 | Bus driver enable |
| rxd | output | 1 | Receive data to host, or wake indication |
| txd_strong_pd | output | 1 | Selects strong pull-down on the transmit pin |

## Verification
Three pairs of events can land in the same clock cycle:
- the remote and local wake filters both expiring;
- a wake filter expiring while the host raises enable;
- a recovery count running while the transmit line drops again.

The first pair is forced by dropping the bus and the wake pin on the same edge, so both counters saturate together. The bench then expects the local source to be reported. The second pair is forced by raising enable on the final filter cycle. The bench then expects normal mode with the bus visible on the receive pin rather than a wake indication. Random dominant-pulse lengths around the filter limit are judged against a simple length-versus-limit rule.

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int WAKE_FILT_US = 100,
  parameter int TXTO_US      = 12000,
  parameter int RECOV_US     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic en,
  input  logic wake_n,
  input  logic bus_rx,
  input  logic txd,
  output logic inh,
  output logic drv_en,
  output logic rxd,
  output logic txd_strong_pd
);
  localparam int WW = $clog2(WAKE_FILT_US + 1);
  localparam int TW = $clog2(TXTO_US + 1);
  localparam int RW = $clog2(RECOV_US + 1);

  typedef enum logic [1:0] {M_STBY = 2'd0, M_NORM = 2'd1, M_SLEEP = 2'd2} mode_t;

  mode_t mode;
  logic wflag, lflag, arm, lock;
  logic [WW-1:0] bcnt, lcnt;
  logic [TW-1:0] tcnt;
  logic [RW-1:0] rcnt;

  wire asleep   = (mode == M_SLEEP);
  wire bus_fire = asleep && !bus_rx && us_tick && (bcnt == WW'(WAKE_FILT_US - 1));
  wire loc_fire = asleep && arm && !wake_n && us_tick && (lcnt == WW'(WAKE_FILT_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_STBY;
      wflag <= 1'b0;
      lflag <= 1'b0;
    end else begin
      case (mode)
        M_STBY: if (en) begin
          mode  <= M_NORM;
          wflag <= 1'b0;
          lflag <= 1'b0;
        end
        M_NORM: if (!en) mode <= M_SLEEP;
        M_SLEEP: begin
          if (en) begin
            mode  <= M_NORM;
            wflag <= 1'b0;
            lflag <= 1'b0;
          end else if (bus_fire || loc_fire) begin
            mode  <= M_STBY;
            wflag <= 1'b1;
            lflag <= loc_fire;
          end
        end
        default: mode <= M_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      lcnt <= '0;
      arm  <= 1'b0;
    end else begin
      if (!asleep || bus_rx) bcnt <= '0;
      else if (us_tick)      bcnt <= bcnt + 1'b1;
      if (!asleep)     arm <= 1'b0;
      else if (wake_n) arm <= 1'b1;
      if (!asleep || wake_n || !arm) lcnt <= '0;
      else if (us_tick)              lcnt <= lcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      rcnt <= '0;
      lock <= 1'b0;
    end else if (mode != M_NORM) begin
      tcnt <= '0;
      rcnt <= '0;
      lock <= 1'b0;
    end else if (!lock) begin
      rcnt <= '0;
      if (txd) tcnt <= '0;
      else if (us_tick) begin
        if (tcnt == TW'(TXTO_US - 1)) begin
          lock <= 1'b1;
          tcnt <= '0;
        end else tcnt <= tcnt + 1'b1;
      end
    end else begin
      if (!txd) rcnt <= '0;
      else if (us_tick) begin
        if (rcnt == RW'(RECOV_US - 1)) begin
          lock <= 1'b0;
          rcnt <= '0;
        end else rcnt <= rcnt + 1'b1;
      end
    end
  end

  assign inh           = !asleep;
  assign drv_en        = (mode == M_NORM) && !lock;
  assign rxd           = (mode == M_NORM) ? bus_rx : !wflag;
  assign txd_strong_pd = lflag;
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic us_tick,
  input logic en,
  input logic wake_n,
  input logic bus_rx,
  input logic txd,
  input logic inh,
  input logic drv_en,
  input logic rxd,
  input logic txd_strong_pd
);
  // R3
  sleep_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inh |-> !drv_en);
  // R3
  norm_to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !en) |=> !inh);
  // R4
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(inh) && !$past(en)) |-> (!rxd && !drv_en));
  // R6
  strong_pd_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txd_strong_pd |-> (inh && !drv_en && !rxd));
  // R7
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_strong_pd && en) |=> !txd_strong_pd);
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .en(en), .wake_n(wake_n),
  .bus_rx(bus_rx), .txd(txd), .inh(inh), .drv_en(drv_en), .rxd(rxd),
  .txd_strong_pd(txd_strong_pd)
);

// File: tb/tb_lin_mode_ctrl.sv
module tb_lin_mode_ctrl;
  localparam int FILT = 8, TXTO = 40, RECOV = 3;
  logic clk = 0, rst_n = 0, us_tick = 1, en = 0, wake_n = 1, bus_rx = 1, txd = 1;
  logic inh, drv_en, rxd, txd_strong_pd;
  int errors = 0, checks = 0;

  lin_mode_ctrl #(.WAKE_FILT_US(FILT), .TXTO_US(TXTO), .RECOV_US(RECOV)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .en(en), .wake_n(wake_n),
    .bus_rx(bus_rx), .txd(txd), .inh(inh), .drv_en(drv_en), .rxd(rxd),
    .txd_strong_pd(txd_strong_pd));

  always #5 clk = ~clk;

  function automatic logic exp_wake(int len);
    return len >= FILT;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    en = 1; cyc(1);
    en = 0; cyc(1);
    cyc(1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    cyc(2);
    // R1 reset state
    chk("R1 inh", inh, 1); chk("R1 drv_en", drv_en, 0);
    chk("R1 rxd", rxd, 1); chk("R1 pd", txd_strong_pd, 0);
    rst_n = 1; cyc(1);
    // R2 standby -> normal in one edge
    en = 1; cyc(1);
    chk("R2 drv_en", drv_en, 1);
    bus_rx = 0; #1; chk("R2 rxd dom", rxd, 0);
    bus_rx = 1; #1; chk("R2 rxd rec", rxd, 1);
    // R3 normal -> sleep in one edge
    cyc(1); en = 0; cyc(1);
    chk("R3 inh", inh, 0); chk("R3 drv_en", drv_en, 0); chk("R3 rxd", rxd, 1);
    // R4 boundary: one short of filter, then exact filter
    cyc(1); bus_rx = 0; cyc(FILT - 1); bus_rx = 1; cyc(1);
    chk("R4 short pulse ignored", inh, 0);
    bus_rx = 0; cyc(FILT); bus_rx = 1; cyc(1);
    chk("R4 inh", inh, 1); chk("R4 rxd flag", rxd, 0); chk("R4 drv_en", drv_en, 0);
    chk("R6 remote pd", txd_strong_pd, 0);
    // R7 flags cleared on normal
    en = 1; cyc(1);
    chk("R7 rxd follows bus", rxd, 1);
    bus_rx = 0; #1; chk("R7 rxd dom", rxd, 0); bus_rx = 1;
    cyc(1); en = 0; cyc(2);
    // R5 local wake, boundary
    wake_n = 0; cyc(FILT - 1); wake_n = 1; cyc(1);
    chk("R5 short local ignored", inh, 0);
    wake_n = 0; cyc(FILT); wake_n = 1; cyc(1);
    chk("R5 inh", inh, 1); chk("R5 rxd", rxd, 0);
    chk("R6 local pd", txd_strong_pd, 1);
    en = 1; cyc(1);
    chk("R7 pd cleared", txd_strong_pd, 0);
    // R5 low level present at sleep entry does not wake
    wake_n = 0; en = 0; cyc(1); cyc(3 * FILT);
    chk("R5 no edge no wake", inh, 0);
    wake_n = 1; cyc(1);
    // R8 sleep -> normal without wake
    en = 1; cyc(1);
    chk("R8 direct normal", drv_en, 1);
    // R9 dominant timeout and recovery
    txd = 0; cyc(TXTO - 1);
    chk("R9 before timeout", drv_en, 1);
    cyc(1);
    chk("R9 timeout", drv_en, 0);
    txd = 1; cyc(RECOV - 1);
    chk("R9 recovering", drv_en, 0);
    txd = 0; cyc(1); txd = 1; cyc(RECOV - 1);
    chk("R9 recovery restarted", drv_en, 0);
    cyc(1);
    chk("R9 recovered", drv_en, 1);
    // R10 no tick, no filtering
    en = 0; cyc(2);
    us_tick = 0; bus_rx = 0; cyc(3 * FILT); bus_rx = 1;
    chk("R10 no tick no wake", inh, 0);
    us_tick = 1; cyc(1);
    // R11 both filters together -> local
    wake_n = 0; bus_rx = 0; cyc(FILT); wake_n = 1; bus_rx = 1; cyc(1);
    chk("R11 inh", inh, 1); chk("R11 local wins", txd_strong_pd, 1);
    // R8 enable beats wake in same cycle
    go_sleep();
    bus_rx = 0; cyc(FILT - 1); en = 1; cyc(1); bus_rx = 1; #1;
    chk("R8 en priority drv", drv_en, 1); chk("R8 en priority rxd", rxd, 1);
    en = 0; cyc(2);
    // R4 random pulse lengths
    for (int i = 0; i < 24; i++) begin
      int len;
      go_sleep();
      len = 1 + int'($urandom % (2 * FILT));
      bus_rx = 0; cyc(len); bus_rx = 1; cyc(1);
      chk($sformatf("R4 random len=%0d", len), inh, exp_wake(len));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule